// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing control engine of a byte-addressed serial memory that holds 16384 eight-bit locations. It watches the open-drain clock and data lines of a two-wire I2C bus. It oversamples both lines with the system clock, finds START and STOP conditions, and recognises its device address. It then collects a 14-bit location from two address bytes. Storage is not part of this block. Each accepted data byte leaves as a one-cycle write strobe toward an external page buffer and commit block. A one-cycle commit pulse marks the STOP that closes a write. Read data comes back combinationally for the location shown on the read address port.

The engine keeps one location counter that persists from one transaction to the next. During a write, each accepted byte advances the counter inside its 64-byte page: the low six bits wrap and the bits above them do not change. During a read, each byte sent advances the counter over the whole array, and it wraps from 16383 to 0. This counter is what gives the three read forms:
- a current-location read starts with a read-type device address;
- a random read sets the location with a write that carries no data, then issues a repeated START;
- a sequential read keeps going for as long as the master acknowledges.

With the protect input high, the top quarter of the array is read-only. The engine still acknowledges the device address and both address bytes. It refuses the first data byte aimed at the protected quarter and then ignores the bus until the next START or STOP. While the commit side reports busy, the device address is not acknowledged, so a master can poll for the end of a programming cycle.

The state machine has these states:
- ST_IDLE: no transfer is in progress.
- ST_DEVADR: receiving the device address.
- ST_ADRHI and ST_ADRLO: receiving the two address bytes.
- ST_WRDAT: receiving a data byte.
- ST_ACK: the acknowledge slot driven by the slave.
- ST_TXDAT: sending a data byte.
- ST_MACK: sampling the master's acknowledge.
- ST_IGNORE: waiting out a transfer that is not for this slave.

Its transitions are:
- A START from any state leads to ST_DEVADR.
- A STOP from any state leads to ST_IDLE.
- At the end of each received byte the engine goes to ST_ACK, or to ST_IGNORE when it refuses the byte.
- From ST_ACK, the falling clock edge leads to the stored follow-on state.
- From ST_TXDAT, the eighth falling clock edge leads to ST_MACK.
- From ST_MACK, the falling clock edge leads to ST_TXDAT if the master acknowledged, or to ST_IGNORE if it did not.

Top module: `i2cm_slave_engine`

## Requirements
- R1: A START (data falling while the clock is high) is detected from any state and resets byte framing. The engine starts pulling the data line low (sda_oe rising) only while the clock is low. A START followed at once by a STOP leaves sda_oe at 0.
- R2: The device address byte is acknowledged only when bits 7:4 equal 4'b1010. Bits 3:1 are don't-care and bit 0 selects the direction (0 = write, 1 = read). Any other upper nibble is not acknowledged, and the transfer is ignored.
- R3: While busy is 1 when the device address byte completes, the device address is not acknowledged.
- R4: In a write, the high and low address bytes are both acknowledged. The location is {high[5:0], low[7:0]}, and high bits 7:6 are don't-care. Each accepted data byte gives exactly one single-cycle wr_stb, with wr_addr set to the current location and wr_data set to the byte.
- R5: During a write, each accepted byte advances the location inside a 64-byte page. The low six bits wrap from 63 to 0 and bits 13:6 stay unchanged.
- R6: commit pulses for one cycle on a STOP when at least one data byte was accepted since the last START. Otherwise it stays 0.
- R7: With wp = 1, a data byte aimed at a location whose bits 13:12 are 2'b11 (0x3000 to 0x3FFF) is not acknowledged and produces no wr_stb. The device address and both address bytes are still acknowledged.
- R8: A read with no preceding address returns the byte at the location counter, which is the last accessed location plus one. rd_addr shows the counter.
- R9: In a read, each master acknowledge (data low in the ninth slot) makes the engine send the byte at the next location. The location wraps from 16383 to 0. A master no-acknowledge ends the transfer.
- R10: A write carrying only the two address bytes, followed by a repeated START with a read-type device address, reads from the location just given.
- R11: A START or STOP in the middle of a byte aborts the transfer. The location is not updated, no write is issued, and the next transfer is served normally.
- R12: After reset, sda_oe, wr_stb and commit are 0 and rd_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | 1 pulls the data line low |
| wp | input | 1 | Write protect for the top quarter |
| busy | input | 1 | Commit block is programming |
| wr_stb | output | 1 | One-cycle write request for one byte |
| wr_addr | output | AW (14) | Location of the write request |
| wr_data | output | 8 | Byte of the write request |
| commit | output | 1 | One-cycle pulse: program the buffered writes |
| rd_addr | output | AW (14) | Location counter, addresses the read data |
| rd_data | input | 8 | Byte stored at rd_addr |

## Verification
A wrong state or bit count shows up at the bus within one byte time. The acknowledge slot is missing or falls in the wrong place, or the byte that is shifted out is off by one bit position. A corrupted location counter appears on rd_addr at once, and it shows in the next wr_addr or in the next byte read back. A fault in the page wrap or the full-array wrap shows only on the byte that crosses the boundary, so the bench places writes and reads across those edges. A wrong protect decision shows as a missing acknowledge on the first data byte, and a wrong write decision shows as an extra or missing wr_stb.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_ADRHI,
        ST_ADRLO,
        ST_WRDAT,
        ST_ACK,
        ST_TXDAT,
        ST_MACK,
        ST_IGNORE
    } eng_state_t;

    localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_p, sda_p;
    logic scl_s, scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[STAGES-1:0], scl_i};
            sda_p <= {sda_p[STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_p[STAGES-1];
    assign scl_d = scl_p[STAGES];
    assign sda_s = sda_p[STAGES-1];
    assign sda_d = sda_p[STAGES];

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & ~sda_s & sda_d;
    assign stop_det  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/i2cm_addr_ctr.sv
module i2cm_addr_ctr #(
    parameter int AW = 14,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_page,
    input  logic          inc_full,
    output logic [AW-1:0] addr
);
    logic [PW-1:0] low_next;
    assign low_next = addr[PW-1:0] + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (inc_page)
            addr <= {addr[AW-1:PW], low_next};
        else if (inc_full)
            addr <= addr + 1'b1;
    end
endmodule

// File: rtl/i2cm_slave_engine.sv
module i2cm_slave_engine
    import i2cm_pkg::*;
#(
    parameter int AW   = 14,
    parameter int PW   = 6,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          wp,
    input  logic          busy,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          commit,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);
    localparam int HI_W = AW - 8;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    eng_state_t state, st_n, ret_st, ret_n;
    logic [3:0]      cnt;
    logic [7:0]      shreg, txreg;
    logic [HI_W-1:0] hi_q;
    logic            ack_drv, ackd_n, m_ack, wrote;
    logic            ctr_load, inc_p, inc_f, load_tx, wr_go, hi_ld;
    logic [AW-1:0]   ctr_addr;
    logic            rx_state, byte_end, prot_hit;

    i2cm_line_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cm_addr_ctr #(.AW(AW), .PW(PW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load),
        .load_val({hi_q, shreg}), .inc_page(inc_p), .inc_full(inc_f),
        .addr(ctr_addr)
    );

    assign rx_state = (state == ST_DEVADR) || (state == ST_ADRHI) ||
                      (state == ST_ADRLO)  || (state == ST_WRDAT);
    assign byte_end = scl_fall && (cnt == 4'd8);
    assign prot_hit = wp && (ctr_addr[AW-1:AW-2] == 2'b11);

    // next state and control strobes
    always_comb begin
        st_n     = state;
        ret_n    = ret_st;
        ackd_n   = ack_drv;
        ctr_load = 1'b0;
        inc_p    = 1'b0;
        inc_f    = 1'b0;
        load_tx  = 1'b0;
        wr_go    = 1'b0;
        hi_ld    = 1'b0;
        if (start_det) begin
            st_n   = ST_DEVADR;
            ackd_n = 1'b0;
        end else if (stop_det) begin
            st_n   = ST_IDLE;
            ackd_n = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: ;
                ST_DEVADR: if (byte_end) begin
                    if (shreg[7:4] == DEV_TAG && !busy) begin
                        st_n   = ST_ACK;
                        ackd_n = 1'b1;
                        if (shreg[0]) begin
                            ret_n   = ST_TXDAT;
                            load_tx = 1'b1;
                            inc_f   = 1'b1;
                        end else begin
                            ret_n = ST_ADRHI;
                        end
                    end else begin
                        st_n = ST_IGNORE;
                    end
                end
                ST_ADRHI: if (byte_end) begin
                    st_n   = ST_ACK;
                    ackd_n = 1'b1;
                    ret_n  = ST_ADRLO;
                    hi_ld  = 1'b1;
                end
                ST_ADRLO: if (byte_end) begin
                    st_n     = ST_ACK;
                    ackd_n   = 1'b1;
                    ret_n    = ST_WRDAT;
                    ctr_load = 1'b1;
                end
                ST_WRDAT: if (byte_end) begin
                    if (prot_hit) begin
                        st_n = ST_IGNORE;
                    end else begin
                        st_n   = ST_ACK;
                        ackd_n = 1'b1;
                        ret_n  = ST_WRDAT;
                        wr_go  = 1'b1;
                        inc_p  = 1'b1;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    st_n   = ret_st;
                    ackd_n = 1'b0;
                end
                ST_TXDAT: if (scl_fall && cnt == 4'd7) begin
                    st_n = ST_MACK;
                end
                ST_MACK: if (scl_fall) begin
                    if (m_ack) begin
                        st_n    = ST_TXDAT;
                        load_tx = 1'b1;
                        inc_f   = 1'b1;
                    end else begin
                        st_n = ST_IGNORE;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ret_st   <= ST_IDLE;
            ack_drv  <= 1'b0;
            cnt      <= '0;
            shreg    <= '0;
            txreg    <= '1;
            hi_q     <= '0;
            m_ack    <= 1'b0;
            wrote    <= 1'b0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            commit   <= 1'b0;
        end else begin
            state   <= st_n;
            ret_st  <= ret_n;
            ack_drv <= ackd_n;
            wr_stb  <= wr_go;
            commit  <= stop_det && wrote;
            if (wr_go) begin
                wr_addr <= ctr_addr;
                wr_data <= shreg;
            end
            if (start_det || stop_det)
                wrote <= 1'b0;
            else if (wr_go)
                wrote <= 1'b1;
            if (start_det || stop_det || (st_n != state))
                cnt <= '0;
            else if ((rx_state && scl_rise) || (state == ST_TXDAT && scl_fall))
                cnt <= cnt + 1'b1;
            if (rx_state && scl_rise && !start_det && !stop_det)
                shreg <= {shreg[6:0], sda_s};
            if (hi_ld)
                hi_q <= shreg[HI_W-1:0];
            if (load_tx)
                txreg <= rd_data;
            else if (state == ST_TXDAT && scl_fall)
                txreg <= {txreg[6:0], 1'b1};
            if (state == ST_MACK && scl_rise)
                m_ack <= ~sda_s;
        end
    end

    // outputs
    always_comb begin
        sda_oe  = ((state == ST_ACK) && ack_drv) ||
                  ((state == ST_TXDAT) && !txreg[7]);
        rd_addr = ctr_addr;
    end
endmodule

// File: rtl/i2cm_slave_chk.sv
module i2cm_slave_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          wp,
    input logic          wr_stb,
    input logic [AW-1:0] wr_addr,
    input logic          commit
);
    // R1: pulling the data line low begins only while the clock is low
    assert_drive_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R4: each write request lasts a single cycle
    assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R7: no write request into the protected quarter while protected
    assert_wp_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !($past(wp) && (wr_addr[AW-1:AW-2] == 2'b11)));

    // R6: commit is a one-cycle pulse
    assert_commit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R6: commit follows a STOP, so the clock line is high
    assert_commit_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> scl_i);
endmodule

bind i2cm_slave_engine i2cm_slave_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wp(wp),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .commit(commit)
);

// File: tb/sim_i2cm_slave_engine.sv
module sim_i2cm_slave_engine;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wp = 1'b0, busy = 1'b0;
    logic sda_oe, wr_stb, commit;
    logic [13:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic sda_line;

    int nvec = 0, nbad = 0;
    int wn = 0, commits = 0;
    logic [13:0] wlog_a [0:63];
    logic [7:0]  wlog_d [0:63];
    logic [13:0] exp_ctr = '0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b10};
    endfunction

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem_f(rd_addr);

    i2cm_slave_engine u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .wp(wp), .busy(busy), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .commit(commit),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (wr_stb && wn < 64) begin
            wlog_a[wn] = wr_addr;
            wlog_d[wn] = wr_data;
            wn = wn + 1;
        end
        if (commit) commits = commits + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic tx_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
    endtask

    task automatic tx_byte(input logic [7:0] b, output bit acked);
        tx_bits(b, 8);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = !sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rx_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl_m = 1'b0;
        end
        wq(Q);
        sda_m = mack ? 1'b0 : 1'b1; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input int n,
                            input logic [7:0] seed, output int acks);
        bit a;
        acks = 0;
        bus_start;
        tx_byte(8'hA0, a); if (a) acks++;
        tx_byte(hi, a);    if (a) acks++;
        tx_byte(lo, a);
        if (a) begin acks++; exp_ctr = {hi[5:0], lo}; end
        for (int k = 0; k < n; k++) begin
            tx_byte(8'(seed + k * 17), a);
            if (!a) break;
            acks++;
            exp_ctr = {exp_ctr[13:6], 6'(exp_ctr[5:0] + 6'd1)};
        end
        bus_stop;
    endtask

    task automatic cur_read(input string req);
        bit a;
        logic [7:0] b;
        bus_start;
        tx_byte(8'hA1, a);
        chk(a, req, 0, 1);
        rx_byte(1'b0, b);
        chk(b == mem_f(exp_ctr), req, b, mem_f(exp_ctr));
        exp_ctr = exp_ctr + 14'd1;
        bus_stop;
        chk(rd_addr == exp_ctr, req, rd_addr, exp_ctr);
    endtask

    initial begin
        repeat (20000 * 9) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        bit a;
        int acks, w0, c0;
        logic [7:0] b;
        logic [13:0] base, ea;

        wq(5);
        rst_n = 1'b1;
        wq(5);
        // R12: reset state
        chk(sda_oe == 1'b0, "R12 sda_oe", sda_oe, 0);
        chk(wr_stb == 1'b0, "R12 wr_stb", wr_stb, 0);
        chk(commit == 1'b0, "R12 commit", commit, 0);
        chk(rd_addr == 14'd0, "R12 rd_addr", rd_addr, 0);

        // R1: START then STOP leaves the line released
        bus_start; bus_stop;
        chk(sda_oe == 1'b0, "R1 start-stop", sda_oe, 0);

        // R2: upper nibble sweep, only 1010 is acknowledged
        for (int t = 0; t < 16; t++) begin
            bus_start;
            tx_byte({4'(t), 4'b0000}, a);
            chk(a == (t == 10), "R2 dev nibble", a, (t == 10));
            bus_stop;
        end
        // R2/R6: don't-care bits 3:1, no data means no commit
        c0 = commits;
        for (int k = 0; k < 8; k++) begin
            bus_start;
            tx_byte({4'b1010, 3'(k), 1'b0}, a);
            chk(a, "R2 dont-care bits", a, 1);
            bus_stop;
        end
        chk(commits == c0, "R6 no data no commit", commits, c0);
        chk(wn == 0, "R2 no writes", wn, 0);

        // R4: byte write, high bits 7:6 ignored
        c0 = commits;
        do_write(8'hC1, 8'h23, 1, 8'h5A, acks);
        chk(acks == 4, "R4 acks", acks, 4);
        chk(wn == 1, "R4 strobe count", wn, 1);
        chk(wlog_a[0] == 14'h0123, "R4 wr_addr", wlog_a[0], 14'h0123);
        chk(wlog_d[0] == 8'h5A, "R4 wr_data", wlog_d[0], 8'h5A);
        chk(commits == c0 + 1, "R6 commit once", commits, c0 + 1);

        // R5: page write across the page wrap
        c0 = commits; w0 = wn;
        base = 14'h0A3C;
        do_write(8'h4A, 8'h3C, 8, 8'h10, acks);
        chk(acks == 11, "R5 acks", acks, 11);
        chk(wn == w0 + 8, "R5 strobe count", wn, w0 + 8);
        for (int k = 0; k < 8; k++) begin
            ea = {base[13:6], 6'(base[5:0] + 6'(k))};
            chk(wlog_a[w0 + k] == ea, "R5 page addr", wlog_a[w0 + k], ea);
            chk(wlog_d[w0 + k] == 8'(8'h10 + k * 17), "R5 page data",
                wlog_d[w0 + k], 8'(8'h10 + k * 17));
        end
        chk(commits == c0 + 1, "R6 commit page", commits, c0 + 1);

        // R8: current-location read after the page write
        chk(exp_ctr == 14'h0A04, "R5 counter model", exp_ctr, 14'h0A04);
        cur_read("R8 current read");

        // R10 and R9: random read, then sequential read across the top
        c0 = commits; w0 = wn;
        bus_start;
        tx_byte(8'hA0, a); chk(a, "R10 dev", a, 1);
        tx_byte(8'h3F, a); chk(a, "R10 hi", a, 1);
        tx_byte(8'hFE, a); chk(a, "R10 lo", a, 1);
        exp_ctr = 14'h3FFE;
        bus_start;
        tx_byte(8'hA1, a); chk(a, "R10 read dev", a, 1);
        for (int k = 0; k < 4; k++) begin
            rx_byte(k != 3, b);
            chk(b == mem_f(exp_ctr), "R9 sequential", b, mem_f(exp_ctr));
            exp_ctr = exp_ctr + 14'd1;
        end
        bus_stop;
        chk(rd_addr == 14'h0002, "R9 wrap", rd_addr, 14'h0002);
        chk(commits == c0 && wn == w0, "R6 dummy write", commits, c0);
        cur_read("R8 after wrap");

        // R7: protected quarter
        wp = 1'b1;
        c0 = commits; w0 = wn;
        do_write(8'h30, 8'h05, 2, 8'h77, acks);
        chk(acks == 3, "R7 refuse acks", acks, 3);
        chk(wn == w0, "R7 no strobe", wn, w0);
        chk(commits == c0, "R7 no commit", commits, c0);
        // R7: sweep high bytes with protection on
        for (int hb = 0; hb < 64; hb += 4) begin
            w0 = wn;
            do_write(8'(hb), 8'h80, 1, 8'(hb), acks);
            chk(acks == ((hb < 48) ? 4 : 3), "R7 sweep acks", acks, (hb < 48) ? 4 : 3);
            chk(wn == w0 + ((hb < 48) ? 1 : 0), "R7 sweep strobe", wn, w0 + ((hb < 48) ? 1 : 0));
        end
        wp = 1'b0;
        w0 = wn;
        do_write(8'h30, 8'h05, 1, 8'h99, acks);
        chk(acks == 4, "R7 unprotected", acks, 4);
        chk(wn == w0 + 1 && wlog_a[w0] == 14'h3005, "R7 unprot addr", wlog_a[w0], 14'h3005);

        // R3: busy refuses the device address
        busy = 1'b1;
        bus_start; tx_byte(8'hA0, a); bus_stop;
        chk(!a, "R3 busy nack", a, 0);
        busy = 1'b0;
        bus_start; tx_byte(8'hA0, a); bus_stop;
        chk(a, "R3 idle ack", a, 1);

        // R11: STOP in the middle of the low address byte
        w0 = wn;
        bus_start;
        tx_byte(8'hA0, a);
        tx_byte(8'h12, a);
        tx_bits(8'h34, 4);
        bus_stop;
        chk(rd_addr == exp_ctr, "R11 stop abort counter", rd_addr, exp_ctr);
        // R11: START in the middle of the high address byte
        bus_start;
        tx_byte(8'hA0, a);
        tx_bits(8'h05, 4);
        bus_start;
        tx_byte(8'hA1, a);
        chk(a, "R11 after start abort", a, 1);
        rx_byte(1'b0, b);
        chk(b == mem_f(exp_ctr), "R11 read after abort", b, mem_f(exp_ctr));
        exp_ctr = exp_ctr + 14'd1;
        bus_stop;
        chk(wn == w0, "R11 no write", wn, w0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule